// File: doc/BRIEF.md
# Field-Indexed Hadamard Transform Unit

This block takes one probability vector of q = 2^M signed fixed-point likelihoods, one per element of GF(2^M), and returns its Walsh–Hadamard transform. This is the domain change a Fourier-domain check-node update needs. Input slot 0 holds the likelihood of the zero element. Slot k+1 holds the likelihood of the k-th power of the primitive element. Before the butterflies run, the block moves each value to the slot given by that element's binary-vector (polynomial) form. It works that form out from the primitive polynomial parameter when the design is elaborated.

The butterflies are built as a constant-geometry network, so the coefficients come out in sequential order. Each output slot j then receives the coefficient whose index is the polynomial form of input element j. Output and input therefore share the same element order. When the request's normalize flag is set, each coefficient is divided by the first coefficient, which is the sum of all inputs.

A whole vector is loaded in parallel under a valid/ready handshake. It appears one cycle later on an output port that has its own valid/ready pair. A parameter sets how the words grow: they either widen by one bit per stage or are halved with an arithmetic shift at every stage. A second parameter lets a new vector be accepted in the same cycle the previous result leaves.

Top module: `gf_hadamard`

## Requirements
- R1: After synchronous reset, out_vld is 0 and in_rdy is 1.
- R2: Input slot 0 is the zero element and slot k+1 is alpha^k. The polynomial index of alpha^k is found by starting at 1 and multiplying by x, reduced by POLY, k times. For GF(8) with x^3+x+1 this maps slots 0..7 to indices 0,1,2,4,3,6,7,5.
- R3: The coefficient at index u equals the sum over indices p of (-1)^popcount(u AND p) times the input at p. Output slot j carries the coefficient at the polynomial index of element j. Slot j of out_data is bits [j*OW +: OW].
- R4: With normalization off, output slot 0 equals the sum of all q inputs.
- R5: In widening mode, OW = DW+M, and no input pattern overflows, including inputs at full-scale positive and full-scale negative.
- R6: With norm_en set and a nonzero first coefficient c0, each slot holds (c*2^FRAC)/c0, truncated toward zero and saturated to the signed OW-bit range. Slot 0 then holds 2^FRAC.
- R7: With norm_en set and c0 equal to 0, the slots hold the unnormalized coefficients.
- R8: A vector accepted at a clock edge (in_vld and in_rdy) gives out_vld=1 after that edge. While out_rdy is 0, out_vld and out_data hold. The data stays unchanged until the next acceptance.
- R9: With PIPE=0, in_rdy is 0 whenever out_vld is 1. It returns to 1 in the cycle after the result is taken (out_vld and out_rdy).
- R10: norm_en is sampled only at acceptance. Changing it while a result waits does not alter out_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input vector valid |
| in_rdy | output | 1 | Block can accept a vector |
| in_data | input | Q*DW | Likelihoods, slot j at [j*DW +: DW], power order |
| norm_en | input | 1 | Normalize this vector by its first coefficient |
| out_vld | output | 1 | Result valid |
| out_rdy | input | 1 | Consumer takes the result |
| out_data | output | Q*OW | Coefficients, slot j at [j*OW +: OW], power order |

## Verification
The hardest cases to reach are the arithmetic edges. One is a vector whose first coefficient is exactly zero while normalization is requested. Another is a set of inputs whose signs line up with one Hadamard row, so a single coefficient reaches its largest magnitude. Random likelihoods almost never produce either one. The stimulus therefore builds them on purpose: a zero-sum pair, all-maximum and all-minimum vectors, and a vector with alternating signs chosen from the popcount of each element's polynomial index. Single impulses placed at chosen power slots expose the index permutation directly. Random vectors then run with random stall lengths, and norm_en is toggled during the stall.

// File: rtl/gfh_pkg.sv
package gfh_pkg;

    typedef enum logic {
        GROW_WIDEN = 1'b0,
        GROW_SCALE = 1'b1
    } growth_e;

    // Polynomial (binary vector) form of the element held in power-order slot j.
    function automatic int pow_to_poly(int m, int poly, int j);
        int v;
        if (j == 0) return 0;
        v = 1;
        for (int k = 1; k < j; k++) begin
            v = v << 1;
            if (((v >> m) & 1) != 0) v = v ^ poly;
        end
        return v;
    endfunction

endpackage

// File: rtl/gfh_stage.sv
module gfh_stage #(
    parameter int Q = 8,
    parameter int W = 11,
    parameter gfh_pkg::growth_e GROWTH = gfh_pkg::GROW_WIDEN
) (
    input  logic signed [W-1:0] x [Q],
    output logic signed [W-1:0] y [Q]
);
    localparam int HALF = Q / 2;

    // Constant-geometry butterfly: adjacent pairs feed low/high halves.
    generate
        if (GROWTH == gfh_pkg::GROW_WIDEN) begin : g_widen
            always_comb begin
                for (int i = 0; i < HALF; i++) begin
                    y[i]        = x[2*i] + x[2*i+1];
                    y[i + HALF] = x[2*i] - x[2*i+1];
                end
            end
        end else begin : g_scale
            always_comb begin
                for (int i = 0; i < HALF; i++) begin
                    y[i]        = W'(($signed({x[2*i][W-1], x[2*i]}) +
                                      $signed({x[2*i+1][W-1], x[2*i+1]})) >>> 1);
                    y[i + HALF] = W'(($signed({x[2*i][W-1], x[2*i]}) -
                                      $signed({x[2*i+1][W-1], x[2*i+1]})) >>> 1);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gfh_norm.sv
module gfh_norm #(
    parameter int W    = 11,
    parameter int FRAC = 4
) (
    input  logic signed [W-1:0] num,
    input  logic signed [W-1:0] den,
    input  logic                en,
    output logic signed [W-1:0] res
);
    localparam int QW = W + FRAC + 1;
    localparam logic signed [QW-1:0] HI = QW'(2**(W-1) - 1);
    localparam logic signed [QW-1:0] LO = QW'(-(2**(W-1)));

    logic signed [QW-1:0] quo;

    always_comb begin
        quo = '0;
        if (den != '0) quo = (QW'(num) <<< FRAC) / QW'(den);
        if (!en || den == '0)  res = num;
        else if (quo > HI)     res = HI[W-1:0];
        else if (quo < LO)     res = LO[W-1:0];
        else                   res = quo[W-1:0];
    end
endmodule

// File: rtl/gf_hadamard.sv
module gf_hadamard #(
    parameter int M    = 3,
    parameter int POLY = 11,
    parameter int DW   = 8,
    parameter int FRAC = 4,
    parameter gfh_pkg::growth_e GROWTH = gfh_pkg::GROW_WIDEN,
    parameter int PIPE = 0
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_vld,
    output logic                           in_rdy,
    input  logic [(1<<M)*DW-1:0]           in_data,
    input  logic                           norm_en,
    output logic                           out_vld,
    input  logic                           out_rdy,
    output logic [(1<<M)*((GROWTH == gfh_pkg::GROW_WIDEN) ? DW+M : DW)-1:0] out_data
);
    localparam int Q  = 1 << M;
    localparam int OW = (GROWTH == gfh_pkg::GROW_WIDEN) ? DW + M : DW;

    logic signed [OW-1:0] xp   [Q];
    logic signed [OW-1:0] coef [Q];
    logic signed [OW-1:0] res  [Q];
    logic signed [OW-1:0] out_q[Q];
    logic                 take;

    // Power order -> polynomial index order, sign-extended to working width.
    always_comb begin
        for (int j = 0; j < Q; j++) xp[j] = '0;
        for (int j = 0; j < Q; j++)
            xp[gfh_pkg::pow_to_poly(M, POLY, j)] = OW'($signed(in_data[j*DW +: DW]));
    end

    generate
        for (genvar s = 0; s < M; s++) begin : g_st
            logic signed [OW-1:0] src [Q];
            logic signed [OW-1:0] dst [Q];
            if (s == 0) begin : g_first
                assign src = xp;
            end else begin : g_next
                assign src = g_st[s-1].dst;
            end
            gfh_stage #(.Q(Q), .W(OW), .GROWTH(GROWTH)) u_stage (
                .x(src),
                .y(dst)
            );
        end
    endgenerate

    assign coef = g_st[M-1].dst;

    // Back to power order, then optional division by the DC coefficient.
    generate
        for (genvar j = 0; j < Q; j++) begin : g_out
            localparam int P = gfh_pkg::pow_to_poly(M, POLY, j);
            gfh_norm #(.W(OW), .FRAC(FRAC)) u_norm (
                .num(coef[P]),
                .den(coef[0]),
                .en (norm_en),
                .res(res[j])
            );
            assign out_data[j*OW +: OW] = out_q[j];
        end
    endgenerate

    assign in_rdy = (PIPE != 0) ? (!out_vld || out_rdy) : !out_vld;
    assign take   = in_vld && in_rdy;

    always_ff @(posedge clk) begin
        if (rst)          out_vld <= 1'b0;
        else if (take)    out_vld <= 1'b1;
        else if (out_rdy) out_vld <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (take) out_q <= res;
    end
endmodule

// File: rtl/gfh_checker.sv
module gfh_checker #(
    parameter int DWID = 88,
    parameter int PIPE = 0
) (
    input logic            clk,
    input logic            rst,
    input logic            in_vld,
    input logic            in_rdy,
    input logic            out_vld,
    input logic            out_rdy,
    input logic [DWID-1:0] out_data
);
    // R1: first cycle out of reset shows an empty output register
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_vld && in_rdy));

    // R8: acceptance produces a result on the next cycle
    a_r8_result_follows: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_rdy) |=> out_vld);

    // R8: a stalled result keeps both valid and data
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_rdy) |=> (out_vld && $stable(out_data)));

    generate
        if (PIPE == 0) begin : g_seq
            // R9: no acceptance while a result is pending
            a_r9_block_when_full: assert property (@(posedge clk) disable iff (rst)
                out_vld |-> !in_rdy);
            // R9: ready again once the result is taken
            a_r9_ready_after_pop: assert property (@(posedge clk) disable iff (rst)
                (out_vld && out_rdy) |=> in_rdy);
        end
    endgenerate
endmodule

bind gf_hadamard gfh_checker #(.DWID($bits(out_data)), .PIPE(PIPE)) u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_rdy(in_rdy),
    .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data)
);

// File: tb/sim_gf_hadamard.sv
module sim_gf_hadamard;
    localparam int PERIOD = 10;
    localparam int M = 3, Q = 8, DW = 8, FRAC = 4, OW = 11, POLY = 11;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_vld = 1'b0;
    logic            in_rdy;
    logic [Q*DW-1:0] in_data = '0;
    logic            norm_en = 1'b0;
    logic            out_vld;
    logic            out_rdy = 1'b0;
    logic [Q*OW-1:0] out_data;

    int checks = 0;
    int errors = 0;

    gf_hadamard #(.M(M), .POLY(POLY), .DW(DW), .FRAC(FRAC)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_rdy(in_rdy),
        .in_data(in_data), .norm_en(norm_en), .out_vld(out_vld),
        .out_rdy(out_rdy), .out_data(out_data)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic int elem_poly(int j);
        int v;
        if (j == 0) return 0;
        v = 1;
        for (int k = 1; k < j; k++) begin
            v = v << 1;
            if ((v & 8) != 0) v = v ^ POLY;
        end
        return v;
    endfunction

    function automatic int coef_at(int vin[Q], int u);
        int acc = 0;
        for (int i = 0; i < Q; i++)
            acc += ($countones(u & elem_poly(i)) % 2 == 1) ? -vin[i] : vin[i];
        return acc;
    endfunction

    function automatic int expect_slot(int vin[Q], bit nrm, int j);
        int c = coef_at(vin, elem_poly(j));
        int c0 = coef_at(vin, 0);
        int qv;
        if (!nrm || c0 == 0) return c;
        qv = (c * (1 << FRAC)) / c0;
        if (qv > 1023) qv = 1023;
        if (qv < -1024) qv = -1024;
        return qv;
    endfunction

    function automatic int slot(int j);
        return int'($signed(out_data[j*OW +: OW]));
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_vec(int vin[Q], bit nrm, int stall, string req);
        @(negedge clk);
        for (int j = 0; j < Q; j++) in_data[j*DW +: DW] = vin[j][DW-1:0];
        norm_en = nrm;
        in_vld  = 1'b1;
        out_rdy = 1'b0;
        while (!in_rdy) @(negedge clk);
        @(negedge clk);
        in_vld  = 1'b0;
        norm_en = ~nrm;              // R10: late change must be ignored
        check("R8 valid after accept", int'(out_vld), 1);
        check("R9 busy while full", int'(in_rdy), 0);
        for (int j = 0; j < Q; j++) check(req, slot(j), expect_slot(vin, nrm, j));
        repeat (stall) @(negedge clk);
        if (stall > 0) begin
            check("R8 valid held", int'(out_vld), 1);
            for (int j = 0; j < Q; j++)
                check("R10 R8 data held under stall", slot(j), expect_slot(vin, nrm, j));
        end
        out_rdy = 1'b1;
        @(negedge clk);
        out_rdy = 1'b0;
        check("R8 valid drops after pop", int'(out_vld), 0);
        check("R9 ready after pop", int'(in_rdy), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v[Q];
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_vld after reset", int'(out_vld), 0);
        check("R1 in_rdy after reset", int'(in_rdy), 1);

        // R2: impulse at slot 4 (alpha^3 -> index 3)
        for (int i = 0; i < Q; i++) v[i] = 0;
        v[4] = 1;
        run_vec(v, 1'b0, 0, "R3 impulse");
        check("R2 slot2 alpha^1", slot(2), -1);
        check("R2 slot3 alpha^2", slot(3), 1);
        check("R2 slot7 alpha^6", slot(7), -1);
        check("R2 slot6 alpha^5", slot(6), 1);

        // R3: impulses in every slot
        for (int k = 0; k < Q; k++) begin
            for (int i = 0; i < Q; i++) v[i] = 0;
            v[k] = 3 - k;
            run_vec(v, 1'b0, k % 2, "R3 impulse sweep");
        end

        // R4/R5: full scale
        for (int i = 0; i < Q; i++) v[i] = 127;
        run_vec(v, 1'b0, 1, "R5 all max");
        check("R4 sum in slot0", slot(0), 1016);
        for (int i = 0; i < Q; i++) v[i] = -128;
        run_vec(v, 1'b0, 0, "R5 all min");
        check("R4 sum in slot0 negative", slot(0), -1024);
        for (int i = 0; i < Q; i++) v[i] = ($countones(7 & elem_poly(i)) % 2 == 1) ? -128 : 127;
        run_vec(v, 1'b0, 0, "R5 row aligned");
        check("R5 peak coefficient", slot(6), 1020);

        // R6: positive likelihoods normalized
        for (int i = 0; i < Q; i++) v[i] = 10 + i;
        run_vec(v, 1'b1, 2, "R6 normalized");
        check("R6 slot0 is one", slot(0), 16);

        // R7: zero DC coefficient
        for (int i = 0; i < Q; i++) v[i] = 0;
        v[1] = 5; v[5] = -5;
        run_vec(v, 1'b1, 1, "R7 zero divisor");
        check("R7 slot0 zero", slot(0), 0);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < Q; i++) v[i] = int'($urandom_range(255)) - 128;
            run_vec(v, 1'($urandom_range(1)), int'($urandom_range(3)), "R3 R6 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule